// File: doc/BRIEF.md
# Programmable Raster Line Interrupt

This block raises a CPU interrupt request at chosen scan lines of a video frame. It counts horizontal sync strobes since the last vertical sync strobe to know which line is being drawn. When a horizontal sync strobe closes a line, the block compares the low eight bits of the line number with an 8-bit line register written by the CPU. On a match it raises a level request that stays high until the CPU acknowledges it.

Because only the low eight bits take part in the comparison, a programmed line also fires 256 lines later in tall frames. Software can rewrite the register inside a frame to get several interrupts per frame; a new value takes effect at the next line boundary. A register value of zero selects a legacy periodic mode, in which a request is raised on every 52nd line of the frame instead.

Timing generation and interrupt vector supply live elsewhere. The block only consumes sync strobes, a write strobe with data, and an acknowledge pulse.

Top module: `raster_line_irq`

## Requirements
- R1: After reset `irq_o` is low and the line register holds 0, so the block starts in legacy periodic mode.
- R2: With a nonzero register value V, `irq_o` rises in the clock cycle after the `hsync_i` strobe that ends line L where L mod 256 equals V. Line 0 is the line that follows a `vsync_i` strobe, and each `hsync_i` strobe ends the current line and starts the next.
- R3: The line counter is 9 bits wide, so with V nonzero a second request follows at line V+256 in the same frame, for example lines 10 and 266 for V = 10.
- R4: A value written through `wr_en_i`/`wr_data_i` is used from the next line boundary on. A boundary is an `hsync_i` or `vsync_i` strobe that comes after the write cycle. The strobe that ends the line in which the write happened still compares against the previous value.
- R5: Rewriting the register after a request allows a further request at the new line within the same frame.
- R6: With the register at 0, a request is raised after the `hsync_i` strobes that end lines 51, 103, 155 and so on. This gives one request every 52 lines, with the count restarting at each `vsync_i`.
- R7: `irq_o` stays high until a cycle with `ack_i` high, and it is low in the cycle after that. If a new request and `ack_i` arrive in the same cycle, the new request wins and `irq_o` stays high.
- R8: A `vsync_i` strobe restarts the line count at 0. An `hsync_i` strobe in the same cycle as `vsync_i` is not treated as a line end and cannot raise a request.
- R9: `irq_o` never rises except in the cycle after an `hsync_i` strobe that had no `vsync_i` with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | One-cycle strobe marking the end of a scan line |
| vsync_i | input | 1 | One-cycle strobe marking the start of a frame |
| wr_en_i | input | 1 | Write strobe for the line register |
| wr_data_i | input | 8 | Line value to write; 0 selects legacy mode |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
A line counter that is off by one moves every request by a whole line, so the first frame in which it happens is enough to expose it. A counter truncated to eight bits loses the request at line V+256. Staging the register at the wrong time shows up as a request on the line where the write took place, in the same line. A legacy counter with the wrong period or a missed clear at `vsync_i` moves the request away from line 51 within the first 52 lines. A request flag that gives ack priority over a new request drops an interrupt in the cycle where both occur.

// File: rtl/raster_line_irq.sv
module raster_line_irq #(
  parameter int LINE_W        = 9,
  parameter int REG_W         = 8,
  parameter int LEGACY_PERIOD = 52
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             ack_i,
  output logic             irq_o
);

  localparam int LEG_W = $clog2(LEGACY_PERIOD);
  localparam logic [LEG_W-1:0] LEG_LAST = LEG_W'(LEGACY_PERIOD - 1);

  logic [REG_W-1:0]  line_wr, line_act;
  logic [LINE_W-1:0] line_cnt;
  logic [LEG_W-1:0]  leg_cnt;
  logic              irq_q;

  wire line_end = hsync_i & ~vsync_i;
  wire boundary = hsync_i | vsync_i;
  wire legacy   = (line_act == '0);
  wire leg_hit  = (leg_cnt == LEG_LAST);
  wire line_hit = (line_cnt[REG_W-1:0] == line_act);
  wire fire     = line_end & (legacy ? leg_hit : line_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_wr  <= '0;
      line_act <= '0;
    end else begin
      if (wr_en_i)  line_wr  <= wr_data_i;
      if (boundary) line_act <= line_wr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_cnt <= '0;
      leg_cnt  <= '0;
    end else if (vsync_i) begin
      line_cnt <= '0;
      leg_cnt  <= '0;
    end else if (hsync_i) begin
      line_cnt <= line_cnt + 1'b1;
      leg_cnt  <= leg_hit ? '0 : leg_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (fire)  irq_q <= 1'b1;
    else if (ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/raster_line_irq_chk.sv
module raster_line_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic hsync,
  input logic vsync,
  input logic ack,
  input logic irq
);

  p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> !irq);

  p_rise_on_line_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hsync && !vsync));

  p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack && !hsync) |=> !irq);

  p_vsync_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !irq) |=> !irq);

endmodule

bind raster_line_irq raster_line_irq_chk u_chk (
  .clk   (clk_i),
  .rst_n (rst_ni),
  .hsync (hsync_i),
  .vsync (vsync_i),
  .ack   (ack_i),
  .irq   (irq_o)
);

// File: tb/tb_raster_line_irq.sv
module tb_raster_line_irq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0, wr_en = 1'b0, ack = 1'b0;
  logic [7:0] wr_data = '0;
  logic irq;

  int total = 0;
  int failed = 0;
  int cur_line = 0;
  int got;
  bit done = 1'b0;

  always #10 clk = ~clk;

  raster_line_irq dut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .vsync_i(vsync),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .ack_i(ack), .irq_o(irq)
  );

  // {register value, first line expected to fire}
  localparam int VEC [5][2] = '{'{1, 1}, '{10, 10}, '{255, 255}, '{200, 200}, '{0, 51}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input int v);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'(v);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic frame_start();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
    cur_line = 0;
  endtask

  task automatic end_line(input bit with_ack);
    @(negedge clk); hsync = 1'b1; ack = with_ack;
    @(negedge clk); hsync = 1'b0; ack = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  // ends lines up to max_line; returns first line whose end raised irq, or -1
  task automatic find_fire(input int max_line, input bit acknowledge, output int line);
    line = -1;
    while (cur_line <= max_line) begin
      end_line(1'b0);
      if (irq) begin
        line = cur_line;
        cur_line++;
        if (acknowledge) do_ack();
        return;
      end
      cur_line++;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R1 irq low in reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R1 irq low after reset", irq, 0);

    // R1: default register 0 -> legacy mode, first request at line 51
    frame_start();
    find_fire(60, 1'b1, got);
    check(got == 51, "R1 default legacy line", got, 51);
    check(irq == 1'b0, "R7 ack clears", irq, 0);

    // table walk: R2 programmable lines, R6 legacy
    foreach (VEC[i]) begin
      write_reg(VEC[i][0]);
      frame_start();
      find_fire(300, 1'b1, got);
      check(got == VEC[i][1], VEC[i][0] == 0 ? "R6 legacy first line" : "R2 match line",
            got, VEC[i][1]);
    end

    // R6: second legacy request at line 103
    find_fire(120, 1'b1, got);
    check(got == 103, "R6 legacy period", got, 103);

    // R3: value 10 fires at 10 and again at 266
    write_reg(10);
    frame_start();
    find_fire(20, 1'b1, got);
    check(got == 10, "R3 first match", got, 10);
    find_fire(300, 1'b1, got);
    check(got == 266, "R3 repeat after 256 lines", got, 266);

    // R5: two requests per frame via rewrite
    write_reg(5);
    frame_start();
    find_fire(10, 1'b1, got);
    check(got == 5, "R5 first request", got, 5);
    write_reg(20);
    find_fire(30, 1'b1, got);
    check(got == 20, "R5 second request", got, 20);

    // R4: write during line 9 of value 9 must not fire at end of line 9
    frame_start();
    find_fire(8, 1'b1, got);
    check(got == -1 || got == 20, "R4 setup", got, -1);
    write_reg(9);
    find_fire(30, 1'b1, got);
    check(got == -1, "R4 write applies from next boundary", got, -1);

    // R7: hold without ack, same-cycle set and ack
    write_reg(3);
    frame_start();
    find_fire(10, 1'b0, got);
    check(got == 3, "R7 setup fire", got, 3);
    repeat (5) @(negedge clk);
    check(irq == 1'b1, "R7 holds without ack", irq, 1);
    write_reg(5);
    end_line(1'b0);            // ends line 4, loads 5
    end_line(1'b1);            // ends line 5 with ack: set wins
    check(irq == 1'b1, "R7 set beats ack", irq, 1);
    do_ack();
    check(irq == 1'b0, "R7 ack clears", irq, 0);

    // R8: hsync with vsync is ignored and restarts the count
    write_reg(1);
    frame_start();
    end_line(1'b0);            // line 0
    @(negedge clk); hsync = 1'b1; vsync = 1'b1;
    @(negedge clk); hsync = 1'b0; vsync = 1'b0;
    cur_line = 0;
    check(irq == 1'b0, "R8 no request on hsync with vsync", irq, 0);
    find_fire(5, 1'b1, got);
    check(got == 1, "R8 count restarted", got, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule